// File: doc/BRIEF.md
# Bank open-row tracker

This block keeps a record, for each of eight SDRAM banks, of whether the bank is open and which row it holds. A memory controller presents each decoded request (bank and row) and the tracker answers in the same cycle with the command the request needs before it may proceed. The answer is a row hit, an activate of a closed bank, or a precharge of a bank that holds some other row. The controller's command scheduler issues that command and pulses a strobe, and the tracker updates its record at the next clock edge.

Banks are never closed to save power or by a timer. Once open, a bank stays open until a miss forces a precharge or until the refresh logic asks for every bank to be closed. To let sequential streams run without stalls, every accepted request arms a speculative activate for the following bank (modulo eight) with the same row. The scheduler may issue it when it has a free command slot. Each bank also keeps a short shift-register history of its open and close events.

The request side is a valid/ready stream. `req_ready` is computed combinationally from the presented bank and row, and rises only for a row hit. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. The source holds the request until then, and the tracker stores no requests. Strobes and the refresh-close input are plain control pins.

Top module: `bank_row_tracker`

## Requirements
- R1: During reset and immediately after it, every bank history is 0, `spec_valid` is 0 and, with no valid request, `cmd_op` is 0 (idle) and `req_ready` is 0.
- R2: `cmd_bank` and `cmd_row` always show the presented `req_bank` and `req_row`.
- R3: A valid request to a closed bank gives `cmd_op` = 2 (activate) with `req_ready` low.
- R4: A valid request to an open bank whose stored row equals `req_row` gives `cmd_op` = 1 (hit) with `req_ready` high. Without a valid request, `cmd_op` is 0 and `req_ready` is 0.
- R5: A valid request to an open bank that holds a different row gives `cmd_op` = 3 (precharge) with `req_ready` low.
- R6: `iss_pre` while `cmd_op` = 3 closes the requested bank at the next edge, shifting a 0 into its history.
- R7: `iss_act` while `cmd_op` = 2 opens the requested bank at the next edge, shifting a 1 into its history and storing `req_row` as the bank's row.
- R8: `iss_pre` and `iss_act` have no effect unless `cmd_op` asks for that command. `spec_iss` has no effect while `spec_valid` is low.
- R9: An accepted request to bank b arms a speculative target of bank (b+1) mod 8 with the same row, replacing any older target. `spec_valid` is high while a target is armed and that bank is closed, and `spec_bank`/`spec_row` show the target.
- R10: `spec_iss` while `spec_valid` is high opens `spec_bank` with `spec_row` (shifting in a 1) and disarms the target, unless a new request is accepted in the same cycle.
- R11: A demand command has priority: in a cycle where `iss_act` or `iss_pre` takes effect, `spec_iss` is ignored and the target stays armed.
- R12: `rfsh_close` shifts a 0 into every bank's history, disarms the speculative target, and overrides every strobe and any acceptance in that cycle.
- R13: Bank b's history is `bank_hist[4b+3:4b]`. Bit 4b is the current open state, and older events sit in higher bits. With no open or close event the history and stored row hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented |
| req_bank | input | 3 | Bank of the request |
| req_row | input | 14 | Row of the request |
| req_ready | output | 1 | Request is a row hit and is accepted this cycle |
| cmd_op | output | 2 | 0 idle, 1 hit, 2 activate, 3 precharge |
| cmd_bank | output | 3 | Bank the demand command targets |
| cmd_row | output | 14 | Row the demand command targets |
| iss_act | input | 1 | Demand activate was issued |
| iss_pre | input | 1 | Demand precharge was issued |
| spec_valid | output | 1 | A speculative activate is available |
| spec_bank | output | 3 | Bank of the speculative activate |
| spec_row | output | 14 | Row of the speculative activate |
| spec_iss | input | 1 | Speculative activate was issued |
| rfsh_close | input | 1 | Refresh logic closes all banks |
| bank_hist | output | 32 | Open/close history, four bits per bank |

## Verification
A demand activate and a speculative activate can be strobed in the same cycle. The bench provokes this by first accepting a hit so that a target is armed for the next bank. It then presents a request to a different, closed bank and pulses `iss_act` and `spec_iss` together. The verdict is that only the demanded bank opens, and that `spec_valid` is still high on the next cycle with the same target. Random traffic also overlaps refresh-close with demand strobes and with acceptances, and a behavioural model judges every such cycle.

// File: rtl/brt_pkg.sv
package brt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_HIT  = 2'd1,
    OP_ACT  = 2'd2,
    OP_PRE  = 2'd3
  } brt_op_e;
endpackage

// File: rtl/brt_bank.sv
module brt_bank #(
  parameter int ROW_W  = 14,
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_open,
  input  logic              do_close,
  input  logic [ROW_W-1:0]  load_row,
  output logic [HIST_W-1:0] hist,
  output logic [ROW_W-1:0]  row,
  output logic              is_open
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      row  <= '0;
    end else if (do_open) begin
      hist <= {hist[HIST_W-2:0], 1'b1};
      row  <= load_row;
    end else if (do_close) begin
      hist <= {hist[HIST_W-2:0], 1'b0};
    end
  end

  assign is_open = hist[0];

  AST_OPEN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    do_open |=> (is_open && row == $past(load_row))); // R7
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_open && !do_close) |=> ($stable(hist) && $stable(row))); // R13
endmodule

// File: rtl/brt_lookup.sv
module brt_lookup
  import brt_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic                        req_valid,
  input  logic [BANK_W-1:0]           req_bank,
  input  logic [ROW_W-1:0]            req_row,
  input  logic [NBANK-1:0]            open_v,
  input  logic [NBANK-1:0][ROW_W-1:0] rows,
  output brt_op_e                     op
);
  always_comb begin
    if (!req_valid)                     op = OP_IDLE;
    else if (!open_v[req_bank])         op = OP_ACT;
    else if (rows[req_bank] == req_row) op = OP_HIT;
    else                                op = OP_PRE;
  end
endmodule

// File: rtl/brt_spec.sv
module brt_spec #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              take,
  input  logic              flush,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  output logic              pend,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      bank <= '0;
      row  <= '0;
    end else if (flush) begin
      pend <= 1'b0;
    end else if (accept) begin
      pend <= 1'b1;
      bank <= req_bank + 1'b1;
      row  <= req_row;
    end else if (take) begin
      pend <= 1'b0;
    end
  end

  AST_NEXT_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !flush) |=> (pend && bank == BANK_W'($past(req_bank) + 1'b1))); // R9
  AST_FLUSH_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pend); // R12
endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
  import brt_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int HIST_W = 4,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [BANK_W-1:0]       req_bank,
  input  logic [ROW_W-1:0]        req_row,
  output logic                    req_ready,
  output logic [1:0]              cmd_op,
  output logic [BANK_W-1:0]       cmd_bank,
  output logic [ROW_W-1:0]        cmd_row,
  input  logic                    iss_act,
  input  logic                    iss_pre,
  output logic                    spec_valid,
  output logic [BANK_W-1:0]       spec_bank,
  output logic [ROW_W-1:0]        spec_row,
  input  logic                    spec_iss,
  input  logic                    rfsh_close,
  output logic [NBANK*HIST_W-1:0] bank_hist
);
  logic [NBANK-1:0]            open_v, do_open, do_close;
  logic [NBANK-1:0][ROW_W-1:0] rows;
  logic [ROW_W-1:0]            load_row;
  brt_op_e                     op;
  logic                        spec_pend, accept, pre_go, act_go, spec_go;

  brt_lookup #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_lookup (
    .req_valid(req_valid), .req_bank(req_bank), .req_row(req_row),
    .open_v(open_v), .rows(rows), .op(op)
  );

  assign cmd_op    = op;
  assign cmd_bank  = req_bank;
  assign cmd_row   = req_row;
  assign req_ready = (op == OP_HIT);
  assign accept    = req_valid && req_ready && !rfsh_close;

  // one tracker event per cycle: refresh, then demand, then speculative
  assign pre_go  = iss_pre && (op == OP_PRE) && !rfsh_close;
  assign act_go  = iss_act && (op == OP_ACT) && !rfsh_close;
  assign spec_go = spec_iss && spec_valid && !rfsh_close && !pre_go && !act_go;
  assign load_row = act_go ? req_row : spec_row;

  brt_spec #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_spec (
    .clk(clk), .rst_n(rst_n), .accept(accept), .take(spec_go),
    .flush(rfsh_close), .req_bank(req_bank), .req_row(req_row),
    .pend(spec_pend), .bank(spec_bank), .row(spec_row)
  );

  assign spec_valid = spec_pend && !open_v[spec_bank];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign do_close[g] = rfsh_close || (pre_go && req_bank == BANK_W'(g));
    assign do_open[g]  = (act_go && req_bank == BANK_W'(g)) ||
                         (spec_go && spec_bank == BANK_W'(g));
    brt_bank #(.ROW_W(ROW_W), .HIST_W(HIST_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .do_open(do_open[g]), .do_close(do_close[g]),
      .load_row(load_row), .hist(bank_hist[g*HIST_W +: HIST_W]),
      .row(rows[g]), .is_open(open_v[g])
    );
  end

  AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    pre_go |=> !open_v[$past(req_bank)]); // R6
  AST_REFRESH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_close |=> (open_v == '0)); // R12
  AST_DEMAND_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (act_go && spec_iss && spec_valid && spec_bank != req_bank) |=> spec_valid); // R11
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_close |-> $countones(do_open | do_close) <= 1); // R11
endmodule

// File: tb/test_bank_row_tracker.sv
module test_bank_row_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, iss_act = 1'b0, iss_pre = 1'b0;
  logic        spec_iss = 1'b0, rfsh_close = 1'b0;
  logic [2:0]  req_bank = '0;
  logic [13:0] req_row = '0;
  logic        req_ready, spec_valid;
  logic [1:0]  cmd_op;
  logic [2:0]  cmd_bank, spec_bank;
  logic [13:0] cmd_row, spec_row;
  logic [31:0] bank_hist;

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model
  int m_hist[8];
  int m_row[8];
  int m_pend = 0, m_sb = 0, m_sr = 0;
  string hist_tag = "R1";

  always #5 clk = ~clk;

  bank_row_tracker i_bank_row_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_row(req_row), .req_ready(req_ready), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .iss_act(iss_act),
    .iss_pre(iss_pre), .spec_valid(spec_valid), .spec_bank(spec_bank),
    .spec_row(spec_row), .spec_iss(spec_iss), .rfsh_close(rfsh_close),
    .bank_hist(bank_hist)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_hist();
    int v = 0;
    for (int i = 0; i < 8; i++) v |= (m_hist[i] & 15) << (4 * i);
    return v;
  endfunction

  // drive at negedge, compare after settling, advance model to next edge
  task automatic step(input bit v, input int bk, input int rw,
                      input bit ia, input bit ip, input bit si, input bit rf);
    int op, spv;
    string otag;
    bit consumed;
    req_valid = v; req_bank = 3'(bk); req_row = 14'(rw);
    iss_act = ia; iss_pre = ip; spec_iss = si; rfsh_close = rf;
    #1;
    if (!v) op = 0;
    else if ((m_hist[bk] & 1) == 0) op = 2;
    else if (m_row[bk] == rw) op = 1;
    else op = 3;
    spv = (m_pend != 0 && (m_hist[m_sb] & 1) == 0) ? 1 : 0;
    otag = (op == 2) ? "R3" : (op == 3) ? "R5" : "R4";
    chk(otag, 32'(cmd_op), 32'(op));
    chk("R4", 32'(req_ready), (op == 1) ? 1 : 0);
    chk("R2", 32'(cmd_bank), 32'(bk));
    chk("R2", 32'(cmd_row), 32'(rw));
    chk("R9", 32'(spec_valid), 32'(spv));
    if (spv != 0) begin
      chk("R9", 32'(spec_bank), 32'(m_sb));
      chk("R9", 32'(spec_row), 32'(m_sr));
    end
    chk(hist_tag, bank_hist, 32'(exp_hist()));
    consumed = 0;
    hist_tag = ((ia && op != 2) || (ip && op != 3) || (si && spv == 0)) ? "R8" : "R13";
    if (rf) begin
      for (int i = 0; i < 8; i++) m_hist[i] = (m_hist[i] << 1) & 15;
      m_pend = 0;
      hist_tag = "R12";
    end else begin
      if (ip && op == 3) begin
        m_hist[bk] = (m_hist[bk] << 1) & 15;
        hist_tag = si ? "R11" : "R6";
      end else if (ia && op == 2) begin
        m_hist[bk] = ((m_hist[bk] << 1) | 1) & 15;
        m_row[bk] = rw;
        hist_tag = si ? "R11" : "R7";
      end else if (si && spv != 0) begin
        m_hist[m_sb] = ((m_hist[m_sb] << 1) | 1) & 15;
        m_row[m_sb] = m_sr;
        consumed = 1;
        hist_tag = "R10";
      end
      if (op == 1) begin
        m_pend = 1; m_sb = (bk + 1) % 8; m_sr = rw;
      end else if (consumed) begin
        m_pend = 0;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_hist[i] = 0; m_row[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk("R1", bank_hist, 0);
    chk("R1", 32'(spec_valid), 0);
    chk("R1", 32'(cmd_op), 0);
    chk("R1", 32'(req_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 0, 0, 0, 0, 0, 0);         // R1 after reset
    step(1, 0, 5, 1, 0, 0, 0);         // R3 then R7: open bank 0 row 5
    step(1, 0, 5, 0, 0, 0, 0);         // R4 hit, arms bank 1 row 5 (R9)
    step(1, 3, 9, 1, 0, 1, 0);         // R11: demand bank 3 beats speculative
    step(0, 0, 0, 0, 0, 1, 0);         // R10: speculative opens bank 1
    step(1, 0, 7, 0, 1, 0, 0);         // R5/R6: miss, precharge bank 0
    step(1, 0, 7, 1, 0, 0, 0);         // R7: reopen with row 7
    step(1, 7, 7, 1, 0, 0, 0);         // open bank 7
    step(1, 7, 7, 0, 0, 0, 0);         // R9 wrap to bank 0 (already open)
    step(1, 0, 7, 1, 1, 0, 0);         // R8: strobes on a hit are ignored
    step(0, 0, 0, 0, 0, 1, 0);         // R8: spec_iss with spec_valid low
    step(1, 2, 1, 1, 0, 0, 1);         // R12: refresh wins over activate
    step(1, 2, 1, 0, 0, 0, 0);         // R3 after refresh
    for (int n = 0; n < 4000; n++) begin
      bit v = ($urandom % 10) < 8;
      step(v, $urandom % 8, $urandom % 3,
           ($urandom % 2) == 1, ($urandom % 5) < 2,
           ($urandom % 2) == 1, ($urandom % 60) == 0);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule